// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block holds the interrupt and error status of an SD host controller and presents it as 32-bit registers on a plain register bus. The bus has an address, a write strobe, write data and registered read data. Engines elsewhere in the controller raise one-cycle event pulses, one bit per status position. The block latches each pulse into a sticky status bit if the status-enable mask allows it. Software clears a status bit by writing a one to it. A second mask, the signal-enable mask, selects which visible status bits drive the single interrupt output.

Several status bits do not latch. Bit 15 is an error summary bit. Bits 8 to 12 show five live level inputs, such as card and function interrupts. An auto-command error field records the detailed outcome of the last automatic command, and any nonzero value in it raises the general auto-command error bit. For test, a write-only injection register can set the command and data error bits, and the auto-command detail bits, without any engine activity.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all status bits, both masks and the auto-command field. After reset every register reads 0 and `irq` is 0.
- R2: An event pulse on `evt_pulse[i]` sets status bit i when bit i of the status-enable mask (0x34) is 1. The latching positions are 0 to 7, 16 to 26, 28 and 29. The bit stays set after the pulse ends.
- R3: An event pulse whose status-enable bit is 0 leaves the status word at 0x30 unchanged.
- R4: Writing the status word at 0x30 clears each latched bit where the write data holds a 1. Bits where the write data holds a 0 keep their value.
- R5: If a status bit is cleared and its event fires on the same clock, the bit stays set.
- R6: Status bit 15 reads 1 exactly when any of bits 16 to 31 is set. Writes to bit 15 have no effect.
- R7: Status bits 8 to 12 read as `live_lvl[0]` to `live_lvl[4]`, each ANDed with its status-enable bit. They are not latched.
- R8: Status bits 13, 14, 27, 30 and 31 always read 0, whatever is pulsed or written.
- R9: A write to 0x50 with a 1 in any of bits 16 to 25 sets the status bit at the same position, subject to the status-enable mask. The other bits of that write have no effect on the status word, and 0x50 reads 0.
- R10: The auto-command field reads at 0x3C in bits 0 to 4 and bit 7 (`acmd_result[4:0]` and `acmd_result[5]`), with all other bits 0. `acmd_load` replaces the field. A write to 0x50 ORs its bits 0 to 4 into field bits 0 to 4 and its bit 7 into field bit 7. One clock after the field becomes nonzero, status bit 24 is set, subject to the status-enable mask.
- R11: The masks at 0x34 and 0x38 are read/write. Only the bits in 0x37FF9FFF are stored, and all other bits read 0.
- R12: `irq` is 1 one clock after any visible status bit and its signal-enable bit are both 1, and 0 one clock after no such pair remains. The summary bit and the live bits count as visible status bits.
- R13: `bus_rdata` shows the register at `bus_addr` as it was at the previous clock edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 32 | Per-bit hardware event pulses |
| live_lvl | input | 5 | Live level sources for status bits 8 to 12 |
| acmd_load | input | 1 | Load strobe for the auto-command field |
| acmd_result | input | 6 | Auto-command outcome, field bits {7,4,3,2,1,0} |
| irq | output | 1 | Interrupt request |

## Verification
Each status write, event pulse, injection and field load takes effect at the edge where it is presented. A read of that state returns the new value one edge later. Status bit 24 follows a nonzero auto-command field by one more edge. `irq` and `bus_rdata` lag the state they reflect by exactly one edge. The bench keeps a model that advances at each rising edge from the inputs held there. It compares `irq` and `bus_rdata` at the following falling edge. Directed reads are issued only after the write or pulse being checked has completed its own cycle.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  localparam int unsigned DW         = 32;
  localparam int unsigned ACMD_W     = 6;
  localparam int unsigned LIVE_W     = 5;
  localparam int unsigned LIVE_LSB   = 8;
  localparam int unsigned SUM_BIT    = 15;
  localparam int unsigned ERR_LSB    = 16;
  localparam int unsigned ACMD_BIT   = 24;

  // bit sets of the status word
  localparam logic [DW-1:0] LATCH_BITS = 32'h37FF_00FF;
  localparam logic [DW-1:0] LIVE_BITS  = 32'h0000_1F00;
  localparam logic [DW-1:0] SUM_MASK   = 32'h0000_8000;
  localparam logic [DW-1:0] MASK_BITS  = LATCH_BITS | LIVE_BITS | SUM_MASK;
  localparam logic [DW-1:0] FORCE_BITS = 32'h03FF_0000;

  // register offsets
  localparam int unsigned OFF_STAT  = 'h30;
  localparam int unsigned OFF_EN    = 'h34;
  localparam int unsigned OFF_SIG   = 'h38;
  localparam int unsigned OFF_ACMD  = 'h3C;
  localparam int unsigned OFF_FORCE = 'h50;

  typedef struct packed {
    logic stat;
    logic en;
    logic sig;
    logic force_evt;
  } wr_sel_t;

endpackage

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs
  import sdh_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     sig_q,
  output logic [DW-1:0]     clr_vec,
  output logic [DW-1:0]     frc_err,
  output logic [ACMD_W-1:0] frc_acmd
);

  wr_sel_t sel;

  always_comb begin
    sel           = '0;
    sel.stat      = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
    sel.en        = bus_we && (bus_addr == ADDR_W'(OFF_EN));
    sel.sig       = bus_we && (bus_addr == ADDR_W'(OFF_SIG));
    sel.force_evt = bus_we && (bus_addr == ADDR_W'(OFF_FORCE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sig_q <= '0;
    end else begin
      if (sel.en)  en_q  <= bus_wdata & MASK_BITS;
      if (sel.sig) sig_q <= bus_wdata & MASK_BITS;
    end
  end

  always_comb begin
    clr_vec  = sel.stat      ? (bus_wdata & LATCH_BITS) : '0;
    frc_err  = sel.force_evt ? (bus_wdata & FORCE_BITS) : '0;
    frc_acmd = sel.force_evt ? {bus_wdata[7], bus_wdata[4:0]} : '0;
  end

  // R11: a mask write lands, restricted to implemented bits
  a_r11_mask_write: assert property (@(posedge clk) disable iff (rst)
    sel.en |=> (en_q == ($past(bus_wdata) & MASK_BITS)));

endmodule

// File: rtl/sdh_irq_acmd.sv
module sdh_irq_acmd
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ACMD_W-1:0] load_val,
  input  logic [ACMD_W-1:0] frc,
  output logic [ACMD_W-1:0] acmd_q,
  output logic              acmd_any
);

  logic [ACMD_W-1:0] base;

  always_comb base = load ? load_val : acmd_q;

  always_ff @(posedge clk) begin
    if (rst) acmd_q <= '0;
    else     acmd_q <= base | frc;
  end

  assign acmd_any = |acmd_q;

  // R10: injected auto-command bits are present on the next cycle
  a_r10_force_sets: assert property (@(posedge clk) disable iff (rst)
    (|frc) |=> ((acmd_q & $past(frc)) == $past(frc)));

endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter logic [DW-1:0] LATCH = LATCH_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] frc_err,
  input  logic          acmd_any,
  input  logic [DW-1:0] en,
  input  logic [DW-1:0] clr,
  output logic [DW-1:0] stat_q
);

  logic [DW-1:0] acmd_vec;
  logic [DW-1:0] set_vec;

  always_comb begin
    acmd_vec           = '0;
    acmd_vec[ACMD_BIT] = acmd_any;
    set_vec            = (evt | frc_err | acmd_vec) & en & LATCH;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= ((stat_q & ~clr) | set_vec) & LATCH;
  end

  // R2 R5: every enabled event is latched, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R3: no bit rises unless its enable was set
  a_r3_gated_rise: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en)) == '0));

  // R4: a cleared bit without a new event falls
  a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~set_vec)) |=> ((stat_q & $past(clr & ~set_vec)) == '0));

endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_pulse,
  input  logic [4:0]        live_lvl,
  input  logic              acmd_load,
  input  logic [5:0]        acmd_result,
  output logic              irq
);

  logic [DW-1:0]     en_q, sig_q, clr_vec, frc_err, stat_q;
  logic [ACMD_W-1:0] frc_acmd, acmd_q;
  logic              acmd_any;
  logic [DW-1:0]     live_vec, sum_vec, vis;
  logic [DW-1:0]     acmd_word, rd_next;
  logic              irq_q;
  logic [DW-1:0]     rdata_q;

  sdh_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .en_q(en_q), .sig_q(sig_q),
    .clr_vec(clr_vec), .frc_err(frc_err), .frc_acmd(frc_acmd)
  );

  sdh_irq_acmd u_acmd (
    .clk(clk), .rst(rst), .load(acmd_load), .load_val(acmd_result),
    .frc(frc_acmd), .acmd_q(acmd_q), .acmd_any(acmd_any)
  );

  sdh_irq_status #(.LATCH(LATCH_BITS)) u_status (
    .clk(clk), .rst(rst), .evt(evt_pulse), .frc_err(frc_err),
    .acmd_any(acmd_any), .en(en_q), .clr(clr_vec), .stat_q(stat_q)
  );

  // visible status word: latched bits, live levels, summary
  always_comb begin
    live_vec                           = '0;
    live_vec[LIVE_LSB +: LIVE_W]       = live_lvl;
    sum_vec                            = '0;
    sum_vec[SUM_BIT]                   = |stat_q[DW-1:ERR_LSB];
    vis = stat_q | (live_vec & en_q & LIVE_BITS) | sum_vec;
  end

  always_comb begin
    acmd_word      = '0;
    acmd_word[4:0] = acmd_q[4:0];
    acmd_word[7]   = acmd_q[5];
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_STAT))      rd_next = vis;
    else if (bus_addr == ADDR_W'(OFF_EN))   rd_next = en_q;
    else if (bus_addr == ADDR_W'(OFF_SIG))  rd_next = sig_q;
    else if (bus_addr == ADDR_W'(OFF_ACMD)) rd_next = acmd_word;
    else                                    rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_next;
      irq_q   <= |(vis & sig_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R12: a latched, signal-enabled bit raises the request next cycle
  a_r12_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & sig_q)) |=> irq);

  // R10: a nonzero auto-command field sets status bit 24 when enabled
  a_r10_acmd_bit: assert property (@(posedge clk) disable iff (rst)
    (acmd_any && en_q[ACMD_BIT]) |=> stat_q[ACMD_BIT]);

endmodule

// File: tb/sdh_irq_ctrl_tb.sv
module sdh_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LATCH = 32'h37FF_00FF;
  localparam logic [31:0] MASKB = 32'h37FF_9FFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_pulse = '0;
  logic [4:0]  live_lvl = '0;
  logic        acmd_load = 1'b0;
  logic [5:0]  acmd_result = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_stat, m_en, m_sig, exp_rdata;
  logic [5:0]  m_acmd;
  logic        exp_irq;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_irq_ctrl #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .live_lvl(live_lvl), .acmd_load(acmd_load), .acmd_result(acmd_result),
    .irq(irq)
  );

  function automatic logic [31:0] f_vis(input logic [31:0] st, input logic [31:0] en,
                                        input logic [4:0] lv);
    return st | ({19'b0, lv, 8'b0} & en & 32'h0000_1F00) | {16'b0, |st[31:16], 15'b0};
  endfunction

  function automatic logic [31:0] f_read(input logic [7:0] a);
    case (a)
      8'h30:   return f_vis(m_stat, m_en, live_lvl);
      8'h34:   return m_en;
      8'h38:   return m_sig;
      8'h3C:   return {24'b0, m_acmd[5], 2'b0, m_acmd[4:0]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one clock: advance the model at the edge, compare at the falling edge
  task automatic tick();
    logic [31:0] set, clr;
    logic [5:0]  nac;
    @(posedge clk);
    exp_rdata = f_read(bus_addr);
    exp_irq   = |(f_vis(m_stat, m_en, live_lvl) & m_sig);
    set = evt_pulse & LATCH;
    if (bus_we && bus_addr == 8'h50) set = set | (bus_wdata & 32'h03FF_0000);
    if (|m_acmd) set[24] = 1'b1;
    set = set & m_en;
    clr = (bus_we && bus_addr == 8'h30) ? (bus_wdata & LATCH) : 32'h0;
    nac = acmd_load ? acmd_result : m_acmd;
    if (bus_we && bus_addr == 8'h50) nac = nac | {bus_wdata[7], bus_wdata[4:0]};
    if (bus_we && bus_addr == 8'h34) m_en = bus_wdata & MASKB;
    if (bus_we && bus_addr == 8'h38) m_sig = bus_wdata & MASKB;
    m_stat = ((m_stat & ~clr) | set) & LATCH;
    m_acmd = nac;
    @(negedge clk);
    chk("R13 rdata", bus_rdata, exp_rdata);
    chk("R12 irq", {31'b0, irq}, {31'b0, exp_irq});
  endtask

  task automatic idle();
    bus_we = 1'b0; bus_wdata = '0; evt_pulse = '0; acmd_load = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    tick();
    idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    tick();
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    evt_pulse = e;
    tick();
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_stat = '0; m_en = '0; m_sig = '0; m_acmd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h30, v); chk("R1 status", v, 32'h0);
    rd(8'h34, v); chk("R1 enable mask", v, 32'h0);
    rd(8'h3C, v); chk("R1 acmd field", v, 32'h0);

    // R3 disabled event is dropped
    pulse(32'h1);
    rd(8'h30, v); chk("R3 masked event", v, 32'h0);

    // R11 mask storage
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R11 enable mask bits", v, 32'h37FF_9FFF);
    wr(8'h38, 32'h0000_0000);
    rd(8'h38, v); chk("R11 signal mask", v, 32'h0);

    // R2 sticky latch
    pulse(32'h2);
    repeat (3) tick();
    rd(8'h30, v); chk("R2 sticky event", v, 32'h2);

    // R7 live levels
    live_lvl = 5'b00101;
    rd(8'h30, v); chk("R7 live shown", v, 32'h502);
    live_lvl = 5'b00000;
    rd(8'h30, v); chk("R7 live not latched", v, 32'h2);

    // R4 write-one-to-clear
    wr(8'h30, 32'h0);
    rd(8'h30, v); chk("R4 zero write keeps", v, 32'h2);
    wr(8'h30, 32'h2);
    rd(8'h30, v); chk("R4 one write clears", v, 32'h0);

    // R5 set beats clear
    evt_pulse = 32'h1; bus_addr = 8'h30; bus_we = 1'b1; bus_wdata = 32'h1;
    tick(); idle();
    rd(8'h30, v); chk("R5 set wins", v, 32'h1);

    // R6 R8 summary and reserved bits
    pulse(32'h0010_0000);
    wr(8'h30, 32'h0800_E000);
    rd(8'h30, v); chk("R6 summary, writes ignored", v, 32'h0010_8001);

    // R12 interrupt through summary bit
    wr(8'h38, 32'h0000_8000);
    rd(8'h38, v); chk("R12 irq asserted", {31'b0, irq}, 32'h1);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R12 irq dropped", {31'b0, irq}, 32'h0);

    // R8 reserved positions never latch
    pulse(32'hFFFF_FFFF);
    rd(8'h30, v); chk("R8 reserved zero", v, 32'h37FF_80FF);
    wr(8'h30, 32'hFFFF_FFFF);

    // R9 R10 force register
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h3C, v); chk("R10 forced acmd field", v, 32'h0000_009F);
    rd(8'h30, v); chk("R9 forced errors", v, 32'h03FF_8000);
    rd(8'h50, v); chk("R9 force reads zero", v, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R10 bit 24 held by field", v, 32'h0100_8000);
    acmd_load = 1'b1; acmd_result = 6'b0;
    tick(); idle();
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R10 cleared after load", v, 32'h0);
    acmd_load = 1'b1; acmd_result = 6'b100100;
    tick(); idle();
    rd(8'h3C, v); chk("R10 loaded field", v, 32'h0000_0084);
    rd(8'h30, v); chk("R10 bit 24 from load", v, 32'h0100_8000);

    // random phase, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 5);
      case (r)
        0: bus_addr = 8'h30;
        1: bus_addr = 8'h34;
        2: bus_addr = 8'h38;
        3: bus_addr = 8'h3C;
        4: bus_addr = 8'h50;
        default: bus_addr = 8'h44;
      endcase
      bus_we      = ($urandom_range(0, 9) < 3);
      bus_wdata   = $urandom() & $urandom();
      evt_pulse   = $urandom() & $urandom() & $urandom();
      live_lvl    = 5'($urandom());
      acmd_load   = ($urandom_range(0, 9) == 0);
      acmd_result = ($urandom_range(0, 3) == 0) ? 6'($urandom()) : 6'b0;
      tick();
    end
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule